// File: doc/BRIEF.md
# External SRAM Access Timing Sequencer

This block turns one internal memory request at a time into a timed strobe sequence on an asynchronous static RAM bus with four chip-select areas. Each area has its own timing byte in a 32-bit configuration register. The byte sets how long the chip enable leads the read or write strobe, how many fixed wait cycles stretch the strobe, and how long the chip enable trails the strobe's release. An active-low wait input lets a slow device stretch the strobe beyond its fixed wait count.

The internal side offers a request when `req_ready` is high. A request carries an address, an area index, a read/write flag and write data. When the access is over, the sequencer returns read data and a one-cycle `done` pulse. The external side drives active-low chip enables, active-low read and write strobes, the address, and a write data bus with its own drive enable.

Top module: `sram_seq_top`

## Requirements
- R1: After reset, all chip enables and both strobes are high, `req_ready` is 1 and `done` is 0. Every area's timing byte resets to 0x3F (setup 0, hold 3, wait 15), so an access gives 1 setup cycle, 16 strobe cycles and 4 hold cycles.
- R2: Area k's timing byte is configuration bits [8k+7:8k]. A setup field S in bits [8k+7:8k+6] holds the chip enable low for S+1 cycles before the strobe falls.
- R3: A static wait field W in bits [8k+3:8k] holds the strobe low for W+1 cycles when the wait input is high. The chip enable stays low throughout.
- R4: A hold field H in bits [8k+5:8k+4] keeps the chip enable low for H+1 cycles after the strobe rises.
- R5: During an access only `ce_n[req_area]` goes low. The other three chip enables stay high.
- R6: `req_write`=1 pulses `wr_n`, and `mem_oe` and `mem_dout` are driven for the whole access. `req_write`=0 pulses `rd_n`, and `mem_oe` stays 0. `mem_addr` holds the request address. The two strobes are never low together.
- R7: `wait_n` passes through a two-flop synchronizer. Once the static count is used up, the strobe stays low while the synchronized wait is low. A release of `wait_n` ends the strobe on the third rising edge after it.
- R8: A low on `wait_n` that is over before the last static wait cycle has no effect on the strobe length.
- R9: `rd_data` takes `mem_din` on the edge on which the read strobe rises, and keeps that value during the hold phase.
- R10: `done` is high for exactly one cycle, in the first cycle after the hold phase. A request is accepted only while `req_ready` is high. Requests made while busy are dropped.
- R11: A configuration write affects only accesses accepted after it. An access in progress keeps the timing it was accepted with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write value, one timing byte per area |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 2 | Chip-select area of the request |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| ce_n | output | 4 | Active-low chip enables, one per area |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_oe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | External read data |
| wait_n | input | 1 | Active-low asynchronous wait from the device |

## Verification
Several properties are checked on every cycle. At most one chip enable is low. A strobe is never low without its chip enable, and the two strobes are never low together. A strobe with static count left cannot end. A synchronized wait after the static count keeps the strobe low. Read data equals the bus value at the strobe's release, and `done` is a single pulse. Only the bench's scenarios can show the exact phase lengths for each field value, the latency of the synchronizer, that an early wait pulse is dropped, and that a configuration write or request made mid-access leaves that access untouched.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  localparam int AREAS    = 4;
  localparam int AREA_W   = $clog2(AREAS);
  localparam int BYTE_W   = 8;
  localparam int CFG_W    = AREAS * BYTE_W;
  localparam int CNT_W    = 4;
  localparam logic [BYTE_W-1:0] AREA_RESET = 8'h3F;
  localparam logic [CFG_W-1:0]  CFG_RESET  = {AREAS{AREA_RESET}};

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // field order inside one area byte: setup[7:6], hold[5:4], static wait[3:0]
  typedef struct packed {
    logic [1:0]       setup;
    logic [1:0]       hold;
    logic [CNT_W-1:0] stat;
  } timing_t;

  function automatic timing_t byte_to_timing(input logic [BYTE_W-1:0] b);
    return timing_t'(b);
  endfunction

  // counter preload for each phase: phase lasts (preload + 1) cycles
  function automatic logic [CNT_W-1:0] setup_load(input timing_t t);
    return {{(CNT_W-2){1'b0}}, t.setup};
  endfunction

  function automatic logic [CNT_W-1:0] hold_load(input timing_t t);
    return {{(CNT_W-2){1'b0}}, t.hold};
  endfunction

  function automatic logic [CNT_W-1:0] strobe_load(input timing_t t);
    return t.stat;
  endfunction
endpackage

// File: rtl/sram_seq_cfg.sv
module sram_seq_cfg
  import sram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [AREA_W-1:0] sel,
  output timing_t           sel_timing
);
  logic [CFG_W-1:0] cfg_q;
  timing_t          area_t [AREAS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RESET;
    else if (we) cfg_q <= wdata;
  end

  for (genvar g = 0; g < AREAS; g++) begin : g_area
    assign area_t[g] = byte_to_timing(cfg_q[g*BYTE_W +: BYTE_W]);
  end

  assign sel_timing = area_t[sel];
endmodule

// File: rtl/sram_seq_sync.sv
module sram_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  timing_t           req_timing,
  input  logic              wait_clear,
  input  logic [DATA_W-1:0] mem_din,
  output phase_e            phase,
  output logic [AREA_W-1:0] area_q,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              ready
);
  logic [CNT_W-1:0] cnt;
  timing_t          t_q;

  // named internal events
  logic accept, cnt_zero, static_busy, wait_stretch, strobe_end, hold_end;

  assign ready        = (phase == PH_IDLE);
  assign accept       = ready && req_valid;
  assign cnt_zero     = (cnt == '0);
  assign static_busy  = (phase == PH_STROBE) && !cnt_zero;
  assign wait_stretch = (phase == PH_STROBE) && cnt_zero && !wait_clear;
  assign strobe_end   = (phase == PH_STROBE) && cnt_zero && wait_clear;
  assign hold_end     = (phase == PH_HOLD) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      t_q     <= '0;
      area_q  <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase   <= PH_SETUP;
            cnt     <= setup_load(req_timing);
            t_q     <= req_timing;
            area_q  <= req_area;
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase <= PH_STROBE;
            cnt   <= strobe_load(t_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (strobe_end) begin
            phase <= PH_HOLD;
            cnt   <= hold_load(t_q);
            if (!write_q) rd_data <= mem_din;
          end
        end
        PH_HOLD: begin
          if (hold_end) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: static wait cycles cannot be cut short
  a_r3_static_keeps_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    static_busy |=> (phase == PH_STROBE));

  // R7: synchronized wait after the static count stretches the strobe
  a_r7_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stretch |=> (phase == PH_STROBE));

  // R4: hold phase ends with a completion pulse
  a_r4_hold_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |=> (done && phase == PH_IDLE));

  // R9: read data is the bus value at strobe release
  a_r9_capture_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_end && !write_q) |=> (rd_data == $past(mem_din)));

  // R10: a busy sequencer keeps its latched request
  a_r10_busy_keeps_request: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(addr_q) && $stable(area_q) && $stable(write_q)));
endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [AREAS-1:0]  ce_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_oe,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              wait_n
);
  timing_t           req_timing;
  logic              wait_clear;
  phase_e            phase;
  logic [AREA_W-1:0] area_q;
  logic              write_q;
  logic              busy;
  logic              strobe_on;

  sram_seq_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .sel        (req_area),
    .sel_timing (req_timing)
  );

  sram_seq_sync #(.STAGES(2)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wait_n),
    .q     (wait_clear)
  );

  sram_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_area   (req_area),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_timing (req_timing),
    .wait_clear (wait_clear),
    .mem_din    (mem_din),
    .phase      (phase),
    .area_q     (area_q),
    .write_q    (write_q),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dout),
    .rd_data    (rd_data),
    .done       (done),
    .ready      (req_ready)
  );

  assign busy      = (phase != PH_IDLE);
  assign strobe_on = (phase == PH_STROBE);
  assign rd_n      = !(strobe_on && !write_q);
  assign wr_n      = !(strobe_on && write_q);
  assign mem_oe    = busy && write_q;

  for (genvar k = 0; k < AREAS; k++) begin : g_ce
    assign ce_n[k] = !(busy && (area_q == AREA_W'(k)));
  end

  // R5: never more than one area selected
  a_r5_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

  // R6: read and write strobes are exclusive
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3: a strobe is always inside an asserted chip enable
  a_r3_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (ce_n != '1));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: an idle sequencer leaves the bus quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n == '1 && rd_n && wr_n && !mem_oe));
endmodule

// File: tb/sram_seq_top_test.sv
`timescale 1ns/1ps
module sram_seq_top_test;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_area = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done;
  logic [DW-1:0] rd_data;
  logic [3:0]    ce_n;
  logic          rd_n, wr_n, mem_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din = 16'hDEAD;
  logic          wait_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sram_seq_top #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_oe(mem_oe),
    .mem_din(mem_din), .wait_n(wait_n)
  );

  // vector: area[31:30] wr[29] S[28:27] H[26:25] W[24:21] expS[20:16] expB[15:11] expH[10:6]
  function automatic logic [31:0] mkv(int a, int w, int s, int h, int st,
                                      int es, int eb, int eh);
    return {2'(a), 1'(w), 2'(s), 2'(h), 4'(st), 5'(es), 5'(eb), 5'(eh), 6'd0};
  endfunction

  localparam logic [31:0] VEC [NV] = '{
    mkv(0, 0, 0, 0, 0,  1, 1,  1),
    mkv(1, 1, 3, 3, 15, 4, 16, 4),
    mkv(2, 0, 1, 2, 5,  2, 6,  3),
    mkv(3, 1, 2, 1, 1,  3, 2,  2),
    mkv(0, 1, 0, 3, 9,  1, 10, 4),
    mkv(3, 0, 3, 0, 2,  4, 3,  1)
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'h5A5A;
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0: plain; 1: wait low from start, released after k strobe samples;
  // 2: one-cycle wait pulse at first strobe sample; 3: config write and request mid-access
  task automatic run_access(input int area, input bit wr, input logic [AW-1:0] addr,
                            input logic [DW-1:0] wd, input int mode, input int k,
                            output int sc, output int bc, output int hc,
                            output bit side_ok, output bit done_ok);
    bit seen, got, strb;
    sc = 0; bc = 0; hc = 0; side_ok = 1; done_ok = 1; seen = 0; got = 0;
    if (mode == 1) wait_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_area = 2'(area);
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !got; i++) begin
      if (done) begin
        got = 1;
      end else begin
        if (ce_n[area] == 1'b0) begin
          strb = wr ? !wr_n : !rd_n;
          if (strb) begin
            bc++; seen = 1;
            if (wr && !(mem_oe && mem_dout == wd && rd_n)) side_ok = 0;
            if (!wr && !(!mem_oe && wr_n)) side_ok = 0;
          end else if (!seen) sc++;
          else hc++;
          if (mem_addr != addr) side_ok = 0;
        end else side_ok = 0;
        for (int j = 0; j < 4; j++)
          if (j != area && !ce_n[j]) side_ok = 0;
        if (mode == 1 && bc == k) wait_n = 1'b1;
        if (mode == 2 && bc == 1) wait_n = 1'b0;
        if (mode == 2 && bc == 2) wait_n = 1'b1;
        if (mode == 3 && sc + bc + hc == 2) begin
          req_valid = 1'b1; req_area = 2'((area + 2) % 4); req_write = 1'b0;
          cfg_we = 1'b1; cfg_wdata = 32'h0;
        end
        if (mode == 3 && sc + bc + hc == 3) begin
          req_valid = 1'b0; cfg_we = 1'b0;
        end
        mem_din = !rd_n ? pat(addr) : 16'hDEAD;
        @(negedge clk);
      end
    end
    if (!got) done_ok = 0;
    if (ce_n != 4'hF || !req_ready) side_ok = 0;
    @(negedge clk);
    if (done) done_ok = 0;
    wait_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sc, bc, hc, idle_bad;
    bit sok, dok;
    logic [31:0] cw;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ce_n == 4'hF && rd_n && wr_n, "R1 bus idle in reset", int'(ce_n), 15);
    chk(req_ready && !done, "R1 ready/done in reset", int'({req_ready, done}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default timing 1/16/4
    run_access(2, 0, 24'h000123, '0, 0, 0, sc, bc, hc, sok, dok);
    chk(sc == 1, "R1 default setup", sc, 1);
    chk(bc == 16, "R1 default strobe", bc, 16);
    chk(hc == 4, "R1 default hold", hc, 4);
    chk(rd_data == pat(24'h000123), "R9 default read data", int'(rd_data), int'(pat(24'h000123)));

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      int a;
      logic [AW-1:0] ad;
      e = VEC[v];
      a = int'(e[31:30]);
      ad = AW'(24'h010000 + v * 24'h001111);
      cw = sram_seq_pkg::CFG_RESET;
      cw[a*8 +: 8] = {e[28:27], e[26:25], e[24:21]};
      write_cfg(cw);
      run_access(a, e[29], ad, 16'hC000 + 16'(v), 0, 0, sc, bc, hc, sok, dok);
      chk(sc == int'(e[20:16]), "R2 setup length", sc, int'(e[20:16]));
      chk(bc == int'(e[15:11]), "R3 strobe length", bc, int'(e[15:11]));
      chk(hc == int'(e[10:6]), "R4 hold length", hc, int'(e[10:6]));
      chk(sok, "R5 R6 area select, strobe, data, address", int'(sok), 1);
      chk(dok, "R10 single done pulse", int'(dok), 1);
      if (!e[29])
        chk(rd_data == pat(ad), "R9 read capture", int'(rd_data), int'(pat(ad)));
    end

    // R7: wait held low with W=1, released after 5 strobe cycles -> 7
    write_cfg({24'h3F3F3F, 8'h01});
    run_access(0, 0, 24'h00AAAA, '0, 1, 5, sc, bc, hc, sok, dok);
    chk(bc == 7, "R7 wait stretch W=1", bc, 7);
    chk(rd_data == pat(24'h00AAAA), "R9 read after stretch", int'(rd_data), int'(pat(24'h00AAAA)));
    // R7: W=0, released after 3 -> 5
    write_cfg({24'h3F3F3F, 8'h00});
    run_access(0, 1, 24'h00BBBB, 16'h1234, 1, 3, sc, bc, hc, sok, dok);
    chk(bc == 5, "R7 wait stretch W=0", bc, 5);
    chk(sok, "R6 write data held during stretch", int'(sok), 1);
    // R8: wait low only during early static cycles, W=8 -> 9
    write_cfg({24'h3F3F3F, 8'h08});
    run_access(0, 0, 24'h00CCCC, '0, 1, 2, sc, bc, hc, sok, dok);
    chk(bc == 9, "R8 early wait ignored (held)", bc, 9);
    // R8: one-cycle wait pulse, W=6 -> 7
    write_cfg({24'h3F3F3F, 8'h06});
    run_access(0, 0, 24'h00DDDD, '0, 2, 0, sc, bc, hc, sok, dok);
    chk(bc == 7, "R8 early wait pulse ignored", bc, 7);

    // R10/R11: config write and foreign request mid-access (area1 byte 0x7B: S1 H3 W11)
    write_cfg({16'h3F3F, 8'h7B, 8'h3F});
    run_access(1, 0, 24'h00EEEE, '0, 3, 0, sc, bc, hc, sok, dok);
    chk(sc == 2 && bc == 12 && hc == 4, "R11 access keeps latched timing",
        sc * 10000 + bc * 100 + hc, 21204);
    chk(sok, "R10 busy request dropped, other ce high", int'(sok), 1);
    idle_bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (ce_n != 4'hF || done) idle_bad++;
      @(negedge clk);
    end
    chk(idle_bad == 0, "R10 no access from dropped request", idle_bad, 0);
    // R11: zero config now applies: 1/1/1
    run_access(1, 1, 24'h00F0F0, 16'hBEEF, 0, 0, sc, bc, hc, sok, dok);
    chk(sc == 1 && bc == 1 && hc == 1, "R11 new config applies",
        sc * 10000 + bc * 100 + hc, 10101);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule